// File: doc/BRIEF.md
# UART Sleep-Mode Power Controller

This block decides, for one UART channel, when the channel core may stop its clock and when that clock has to return. It runs from an always-on clock. On every edge of that clock it samples the channel's status:

- the receive-line idle indication produced by the receive time-out logic;
- the empty flags of the transmit FIFO, the transmit shift register and the receive FIFO;
- the vector of pending interrupt sources.

It also watches the raw receive pin and the modem input pins through synchronizers.

Sleep is allowed only while two separate enable bits are both set. The idle test must pass on two consecutive always-on edges before the core clock enable is dropped. The test ignores only the transmit-holding-empty interrupt.

Once asleep, the block holds the core clock enable low until a wake event arrives. Four events wake it:

- a transition on the receive pin;
- a change on any modem pin;
- a write strobe to the transmit FIFO;
- clearing either enable bit.

A wake event always takes priority over an entry that would complete in the same cycle. After any wake, the qualification starts again from zero. Software clears the sleep enable before it writes the baud divisor, so divisor writes never land while the core clock is stopped.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: While reset is asserted and on the first edges after it, `sleep_active` is 0 and `core_clk_en` is 1.
- R2: Sleep is never entered unless `en_enhanced` and `en_sleep` are both 1.
- R3: With both enables set and every idle condition true, `sleep_active` becomes 1 after the second consecutive always-on edge at which everything holds.
- R4: Sleep is not entered while any one of `rx_idle`, `tx_fifo_empty`, `tx_shift_empty` or `rx_fifo_empty` is 0.
- R5: Bit 1 of `irq_pending` (transmit-holding-empty) does not block entry. Any other bit set to 1 blocks entry.
- R6: A `tx_fifo_wr` pulse sampled while asleep clears `sleep_active` at that same edge.
- R7: A level change on `rx_line` while asleep clears `sleep_active` at the third always-on edge after the change (two synchronizer stages plus the state register).
- R8: A level change on any single bit of `modem_in` while asleep clears `sleep_active` with the same three-edge latency as R7.
- R9: Clearing either enable bit while asleep clears `sleep_active` at the next edge.
- R10: A wake event sampled at the edge where entry would complete prevents the entry. After any wake, two fresh qualifying edges are needed before sleep is entered again.
- R11: `core_clk_en` is always the inverse of `sleep_active`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_aon | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_enhanced | input | 1 | Enhanced-functions enable bit |
| en_sleep | input | 1 | Sleep enable bit from the interrupt-enable register |
| rx_line | input | 1 | Raw receive pin, asynchronous, idles high |
| rx_idle | input | 1 | Receive line idle, from the time-out logic |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| rx_fifo_empty | input | 1 | Receive FIFO holds no data |
| irq_pending | input | IRQ_W (6) | Pending interrupt sources; bit 1 is transmit-holding-empty |
| modem_in | input | NUM_MODEM (4) | Raw modem input pins, asynchronous |
| tx_fifo_wr | input | 1 | Transmit FIFO write strobe, one always-on cycle |
| core_clk_en | output | 1 | Enable for the core clock gate; 0 while asleep |
| sleep_active | output | 1 | 1 while the channel is asleep |

## Verification
The entry qualifier finishing its second idle edge and a wake event can land on the same always-on edge. The bench provokes this in two ways. In the first, it raises `tx_fifo_wr` exactly at the edge where the count would complete. In the second, it toggles `rx_line` one cycle before setting the enable, so that the synchronized edge matures on the completing edge. In both cases the scoreboard expects `sleep_active` to stay 0 on that edge and on the next one, and to rise only after two more qualifying edges.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;

  // Bundle of idle indications sampled on the always-on clock
  typedef struct packed {
    logic rx_idle;
    logic tx_fifo_empty;
    logic tx_shift_empty;
    logic rx_fifo_empty;
    logic irq_clear;
  } idle_cond_t;

  typedef enum logic {
    PWR_AWAKE  = 1'b0,
    PWR_ASLEEP = 1'b1
  } pwr_state_e;

  // True when no source other than the ignored ones is pending
  function automatic logic irq_quiet(input logic [31:0] vec,
                                     input logic [31:0] ignore_mask);
    return ((vec & ~ignore_mask) == 32'd0);
  endfunction

  // All idle indications together
  function automatic logic idle_met(input idle_cond_t c);
    return c.rx_idle & c.tx_fifo_empty & c.tx_shift_empty &
           c.rx_fifo_empty & c.irq_clear;
  endfunction

  // Saturating qualification counter step
  function automatic logic [7:0] qual_step(input logic [7:0] cnt,
                                           input logic ok,
                                           input logic [7:0] limit);
    if (!ok)
      return 8'd0;
    else if (cnt >= limit)
      return limit;
    else
      return cnt + 8'd1;
  endfunction

endpackage

// File: rtl/usc_sync_edge.sv
module usc_sync_edge #(
  parameter int               WIDTH     = 1,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_aon,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic             edge_any
);

  logic [WIDTH-1:0] sync_now;
  logic [WIDTH-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] q;
      if (s == 0) begin : g_first
        always_ff @(posedge clk_aon or negedge rst_n) begin
          if (!rst_n) q <= RESET_VAL;
          else        q <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk_aon or negedge rst_n) begin
          if (!rst_n) q <= RESET_VAL;
          else        q <= g_stage[s-1].q;
        end
      end
    end
  endgenerate

  assign sync_now = g_stage[STAGES-1].q;

  // Registered copy, compared with the live synchronized value
  always_ff @(posedge clk_aon or negedge rst_n) begin
    if (!rst_n) prev_q <= RESET_VAL;
    else        prev_q <= sync_now;
  end

  assign edge_any = |(sync_now ^ prev_q);

endmodule

// File: rtl/usc_entry_qual.sv
module usc_entry_qual
  import uart_sleep_pkg::*;
#(
  parameter int QUAL_CYCLES = 2
) (
  input  logic clk_aon,
  input  logic rst_n,
  input  logic cond_ok,
  input  logic hold,
  output logic qual_done
);

  localparam logic [7:0] LIMIT = 8'(QUAL_CYCLES - 1);

  logic [7:0] cnt_q;
  logic       step_ok;

  assign step_ok   = cond_ok & ~hold;
  assign qual_done = step_ok & (cnt_q == LIMIT);

  always_ff @(posedge clk_aon or negedge rst_n) begin
    if (!rst_n) cnt_q <= 8'd0;
    else        cnt_q <= qual_step(cnt_q, step_ok, LIMIT);
  end

  // R10: a failed condition restarts the qualification window
  assert_qual_restart_R10: assert property (@(posedge clk_aon) disable iff (!rst_n)
    !cond_ok |=> !qual_done);

endmodule

// File: rtl/usc_pwr_state.sv
module usc_pwr_state
  import uart_sleep_pkg::*;
(
  input  logic clk_aon,
  input  logic rst_n,
  input  logic enter_req,
  input  logic wake_rx,
  input  logic wake_modem,
  input  logic wake_wr,
  input  logic wake_dis,
  output logic asleep
);

  pwr_state_e state_q, state_d;
  logic       wake_any;

  assign wake_any = wake_rx | wake_modem | wake_wr | wake_dis;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PWR_AWAKE:  if (enter_req && !wake_any) state_d = PWR_ASLEEP;
      PWR_ASLEEP: if (wake_any)               state_d = PWR_AWAKE;
      default:                                state_d = PWR_AWAKE;
    endcase
  end

  always_ff @(posedge clk_aon or negedge rst_n) begin
    if (!rst_n) state_q <= PWR_AWAKE;
    else        state_q <= state_d;
  end

  assign asleep = (state_q == PWR_ASLEEP);

  assert_wake_txwr_R6: assert property (@(posedge clk_aon) disable iff (!rst_n)
    asleep && wake_wr |=> !asleep);
  assert_wake_rx_R7: assert property (@(posedge clk_aon) disable iff (!rst_n)
    asleep && wake_rx |=> !asleep);
  assert_wake_modem_R8: assert property (@(posedge clk_aon) disable iff (!rst_n)
    asleep && wake_modem |=> !asleep);
  assert_wake_disable_R9: assert property (@(posedge clk_aon) disable iff (!rst_n)
    asleep && wake_dis |=> !asleep);
  assert_wake_beats_entry_R10: assert property (@(posedge clk_aon) disable iff (!rst_n)
    !asleep && enter_req && wake_any |=> !asleep);

endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
  import uart_sleep_pkg::*;
#(
  parameter int IRQ_W       = 6,
  parameter int THR_BIT     = 1,
  parameter int NUM_MODEM   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 2
) (
  input  logic                 clk_aon,
  input  logic                 rst_n,
  input  logic                 en_enhanced,
  input  logic                 en_sleep,
  input  logic                 rx_line,
  input  logic                 rx_idle,
  input  logic                 tx_fifo_empty,
  input  logic                 tx_shift_empty,
  input  logic                 rx_fifo_empty,
  input  logic [IRQ_W-1:0]     irq_pending,
  input  logic [NUM_MODEM-1:0] modem_in,
  input  logic                 tx_fifo_wr,
  output logic                 core_clk_en,
  output logic                 sleep_active
);

  localparam logic [31:0] THR_MASK = 32'd1 << THR_BIT;

  logic       permit;
  logic       rx_edge;
  logic       modem_edge;
  logic       wake_any;
  logic       entry_ok;
  logic       qual_done;
  logic       asleep;
  idle_cond_t cond;

  assign permit = en_enhanced & en_sleep;

  usc_sync_edge #(
    .WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)
  ) u_rx_edge (
    .clk_aon(clk_aon), .rst_n(rst_n), .async_in(rx_line), .edge_any(rx_edge)
  );

  usc_sync_edge #(
    .WIDTH(NUM_MODEM), .STAGES(SYNC_STAGES), .RESET_VAL('0)
  ) u_modem_edge (
    .clk_aon(clk_aon), .rst_n(rst_n), .async_in(modem_in), .edge_any(modem_edge)
  );

  always_comb begin
    cond.rx_idle        = rx_idle;
    cond.tx_fifo_empty  = tx_fifo_empty;
    cond.tx_shift_empty = tx_shift_empty;
    cond.rx_fifo_empty  = rx_fifo_empty;
    cond.irq_clear      = irq_quiet(32'(irq_pending), THR_MASK);
  end

  assign entry_ok = permit & idle_met(cond);
  assign wake_any = rx_edge | modem_edge | tx_fifo_wr | ~permit;

  usc_entry_qual #(
    .QUAL_CYCLES(QUAL_CYCLES)
  ) u_qual (
    .clk_aon(clk_aon), .rst_n(rst_n), .cond_ok(entry_ok & ~wake_any),
    .hold(asleep), .qual_done(qual_done)
  );

  usc_pwr_state u_state (
    .clk_aon(clk_aon), .rst_n(rst_n), .enter_req(qual_done),
    .wake_rx(rx_edge), .wake_modem(modem_edge), .wake_wr(tx_fifo_wr),
    .wake_dis(~permit), .asleep(asleep)
  );

  assign sleep_active = asleep;
  assign core_clk_en  = ~asleep;

  assert_reset_awake_R1: assert property (@(posedge clk_aon)
    !rst_n |=> !sleep_active);
  assert_entry_enables_R2: assert property (@(posedge clk_aon) disable iff (!rst_n)
    $rose(sleep_active) |-> $past(en_enhanced && en_sleep));
  assert_entry_two_edges_R3: assert property (@(posedge clk_aon) disable iff (!rst_n)
    $rose(sleep_active) |-> ($past(entry_ok) && $past(entry_ok, 2)));
  assert_entry_rxfifo_R4: assert property (@(posedge clk_aon) disable iff (!rst_n)
    $rose(sleep_active) |-> $past(rx_fifo_empty && tx_fifo_empty && tx_shift_empty));
  assert_entry_irq_R5: assert property (@(posedge clk_aon) disable iff (!rst_n)
    $rose(sleep_active) |-> ((32'($past(irq_pending)) & ~THR_MASK) == 32'd0));

endmodule

// File: tb/uart_sleep_ctrl_tb.sv
module uart_sleep_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_enhanced, en_sleep, rx_line, rx_idle;
  logic       tx_fifo_empty, tx_shift_empty, rx_fifo_empty, tx_fifo_wr;
  logic [5:0] irq_pending;
  logic [3:0] modem_in;
  logic       core_clk_en, sleep_active;

  int  n_chk  = 0;
  int  n_fail = 0;
  int  cycles = 0;
  bit  done   = 1'b0;
  bit  q_exp[$];
  string q_tag[$];

  always #5 clk = ~clk;

  uart_sleep_ctrl u_dut (
    .clk_aon(clk), .rst_n(rst_n), .en_enhanced(en_enhanced), .en_sleep(en_sleep),
    .rx_line(rx_line), .rx_idle(rx_idle), .tx_fifo_empty(tx_fifo_empty),
    .tx_shift_empty(tx_shift_empty), .rx_fifo_empty(rx_fifo_empty),
    .irq_pending(irq_pending), .modem_in(modem_in), .tx_fifo_wr(tx_fifo_wr),
    .core_clk_en(core_clk_en), .sleep_active(sleep_active)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Monitor: pops one expected item per edge, samples 3 ns after the edge
  always @(posedge clk) begin
    #3;
    if (q_exp.size() > 0) begin
      bit    e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_chk++;
      if (sleep_active !== e) begin
        n_fail++;
        $display("FAIL %s: sleep_active=%b expected %b at %0t", t, sleep_active, e, $time);
      end
      n_chk++;
      if (core_clk_en !== !e) begin
        n_fail++;
        $display("FAIL R11: core_clk_en=%b expected %b at %0t", core_clk_en, !e, $time);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      report();
    end
  end

  // Driver: push expected state after the coming edge, then advance one cycle
  task automatic cyc(input bit e, input string tag);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // Restart from awake with a cleared qualifier, then enter sleep
  task automatic arm(input string tag);
    en_sleep = 1'b0;
    cyc(1'b0, tag);
    en_sleep = 1'b1;
    cyc(1'b0, tag);
    cyc(1'b1, tag);
  endtask

  task automatic set_cond(input int idx, input logic v);
    case (idx)
      0: rx_idle        = v;
      1: tx_fifo_empty  = v;
      2: tx_shift_empty = v;
      default: rx_fifo_empty = v;
    endcase
  endtask

  initial begin
    rst_n = 1'b0;
    en_enhanced = 1'b0; en_sleep = 1'b0; rx_line = 1'b1; rx_idle = 1'b1;
    tx_fifo_empty = 1'b1; tx_shift_empty = 1'b1; rx_fifo_empty = 1'b1;
    tx_fifo_wr = 1'b0; irq_pending = '0; modem_in = '0;
    @(negedge clk);
    cyc(1'b0, "R1");
    cyc(1'b0, "R1");
    rst_n = 1'b1;
    cyc(1'b0, "R1");

    // R2: only one enable set at a time
    en_enhanced = 1'b1; en_sleep = 1'b0;
    for (int i = 0; i < 4; i++) cyc(1'b0, "R2");
    en_enhanced = 1'b0; en_sleep = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1'b0, "R2");

    // R3: two qualifying edges then sleep
    en_enhanced = 1'b1;
    cyc(1'b0, "R3");
    cyc(1'b1, "R3");
    cyc(1'b1, "R3");

    // R9: clearing an enable wakes at the next edge
    en_sleep = 1'b0;
    cyc(1'b0, "R9");
    cyc(1'b0, "R9");
    en_sleep = 1'b1;
    cyc(1'b0, "R3");
    cyc(1'b1, "R3");
    en_enhanced = 1'b0;
    cyc(1'b0, "R9");
    en_enhanced = 1'b1;

    // R4: each idle condition blocks entry
    for (int c = 0; c < 4; c++) begin
      en_sleep = 1'b0;
      set_cond(c, 1'b0);
      cyc(1'b0, "R4");
      en_sleep = 1'b1;
      for (int k = 0; k < 3; k++) cyc(1'b0, "R4");
      set_cond(c, 1'b1);
      cyc(1'b0, "R4");
      cyc(1'b1, "R4");
    end

    // R5: transmit-holding-empty bit ignored, others block
    en_sleep = 1'b0;
    irq_pending = 6'b000010;
    cyc(1'b0, "R5");
    en_sleep = 1'b1;
    cyc(1'b0, "R5");
    cyc(1'b1, "R5");
    for (int b = 0; b < 6; b++) begin
      if (b != 1) begin
        en_sleep = 1'b0;
        irq_pending = 6'(1 << b);
        cyc(1'b0, "R5");
        en_sleep = 1'b1;
        for (int k = 0; k < 3; k++) cyc(1'b0, "R5");
      end
    end
    irq_pending = '0;

    // R6: TX FIFO write wakes, then R10 re-qualification
    arm("R6");
    tx_fifo_wr = 1'b1;
    cyc(1'b0, "R6");
    tx_fifo_wr = 1'b0;
    cyc(1'b0, "R10");
    cyc(1'b1, "R10");

    // R7: RX transitions in both directions
    for (int d = 0; d < 2; d++) begin
      arm("R7");
      rx_line = ~rx_line;
      cyc(1'b1, "R7");
      cyc(1'b1, "R7");
      cyc(1'b0, "R7");
      cyc(1'b0, "R10");
      cyc(1'b1, "R10");
    end

    // R8: each modem pin alone
    for (int p = 0; p < 4; p++) begin
      arm("R8");
      modem_in[p] = ~modem_in[p];
      cyc(1'b1, "R8");
      cyc(1'b1, "R8");
      cyc(1'b0, "R8");
    end

    // R10: TX write on the completing edge
    en_sleep = 1'b0;
    cyc(1'b0, "R10");
    en_sleep = 1'b1;
    cyc(1'b0, "R10");
    tx_fifo_wr = 1'b1;
    cyc(1'b0, "R10");
    tx_fifo_wr = 1'b0;
    cyc(1'b0, "R10");
    cyc(1'b1, "R10");

    // R10: synchronized RX edge matures on the completing edge
    en_sleep = 1'b0;
    rx_line = 1'b0;
    cyc(1'b0, "R10");
    en_sleep = 1'b1;
    cyc(1'b0, "R10");
    cyc(1'b0, "R10");
    cyc(1'b0, "R10");
    cyc(1'b1, "R10");

    @(negedge clk);
    @(negedge clk);
    report();
  end

endmodule